// File: doc/BRIEF.md
# Leading-Run Edge Encoder

This block turns one sample of a tapped delay line into a binary run length. The sample is a thermometer-style vector of 2^N-1 bits. Its top bit gives the polarity, which tells whether the captured transition is a rising or a falling one. The encoder counts how many bits, starting at the top, carry that same value. Counting stops at the first bit that differs. Nothing below that bit can change the result, so noise or bubbles further down the line are discarded.

The block is a two-stage pipeline and accepts a new sample on every clock. The first stage finds where the leading run ends and stores that position as a one-hot word. The second stage turns the one-hot word into binary. Alongside the count, it presents the sample's polarity and an event flag. The event flag is high when the polarity differs from the polarity of the sample before it. A downstream time-stamping stage uses the flag to decide that a new transition has arrived.

Top module: `lead_run_encoder`

## Requirements
- R1: `pol_o` equals the top bit (bit 2^N-2) of the sample presented two clock edges earlier. The sample is 2^N-1 bits wide and `cnt_o` is N bits wide.
- R2: `cnt_o` equals the number of consecutive bits, counted downward from the top bit, that equal that top bit. Counting stops at the first bit with the opposite value. When such a bit exists, the count is between 1 and 2^N-2.
- R3: Bits below the first mismatching bit have no effect. Samples that share the same leading run and the same first mismatch, but have different lower bits, give identical outputs.
- R4: A sample whose bits are all equal (all ones or all zeros) gives `cnt_o` = 2^N-1.
- R5: The count, polarity and event for a sample appear exactly two clock edges after it is presented. A new sample may be presented on every clock, with no gaps.
- R6: `evt_o` is 1 in the same cycle as a sample's count when that sample's polarity differs from the previous sample's polarity. It is 0 when the two polarities are equal.
- R7: When samples alternate polarity on every clock, `pol_o` toggles on every cycle and `evt_o` stays 1 on every cycle.
- R8: While `rst_n` is low, `cnt_o`, `pol_o` and `evt_o` are all 0, and the stored previous polarity is cleared to 0. After reset, a first sample with top bit 0 gives `evt_o` = 0, and a first sample with top bit 1 gives `evt_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_i | input | 2^N-1 | Delay-line sample; the top bit is the polarity |
| cnt_o | output | N | Length of the leading run that matches the polarity |
| pol_o | output | 1 | Polarity of the sample two edges back |
| evt_o | output | 1 | Polarity differs from that of the preceding sample |

## Verification
The hardest case to reach from the ports is proving that the bits below the first mismatch are truly ignored. This means that many different tails must give the same output while the event flag stays low. The bench holds a fixed leading run and a fixed mismatch bit at the same polarity for several back-to-back clocks and fills the bits below them with fresh random values each time. A ramp of run lengths from 1 to 2^N-1 with alternating polarity covers every one-hot position and the event toggling. Resets in the middle of a stream, followed by a first sample of each polarity, expose the cleared previous-polarity state.

// File: rtl/lead_run_pkg.sv
package lead_run_pkg;

  // Upper bound on the sample width supported by the helper functions (N <= 10).
  localparam int unsigned MAXW = 1023;

  typedef logic [MAXW-1:0] wide_vec_t;
  typedef logic [MAXW:0]   wide_pos_t;

  // Sample width for a count width n.
  function automatic int unsigned sample_width(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Length of the leading run of v[w-1:0] that matches the top bit v[w-1].
  function automatic int unsigned lead_run(input wide_vec_t v, input int unsigned w);
    int unsigned run;
    logic        stop;
    logic        ref_bit;
    run     = 0;
    stop    = 1'b0;
    ref_bit = v[w-1];
    for (int i = int'(w) - 1; i >= 0; i--) begin
      if (!stop) begin
        if (v[i] == ref_bit) run = run + 1;
        else                 stop = 1'b1;
      end
    end
    return run;
  endfunction

  // Mask of the one-hot positions 0..w whose index has bit b set.
  function automatic wide_pos_t pos_mask(input int unsigned b, input int unsigned w);
    wide_pos_t m;
    m = '0;
    for (int unsigned k = 0; k <= w; k++) m[k] = ((k >> b) & 32'd1) != 0;
    return m;
  endfunction

endpackage

// File: rtl/lead_run_locate.sv
// Stage 1: marks where the leading run ends as a one-hot position.
// Bit k of pos_q is set when the run is exactly k bits long (k = 1..W).
module lead_run_locate #(
  parameter int unsigned N = 5,
  localparam int unsigned W = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec_i,
  output logic [W:0]   pos_q,
  output logic         pol_q
);

  logic         pol_w;
  logic [W-1:0] mism_w;   // mism_w[i]: i-th bit from the top differs from polarity
  logic [W:0]   clean_w;  // clean_w[k]: first k bits from the top all match
  logic [W:0]   pos_next;

  assign pol_w      = vec_i[W-1];
  assign clean_w[0] = 1'b1;

  generate
    for (genvar i = 0; i < int'(W); i++) begin : g_scan
      assign mism_w[i]     = vec_i[W-1-i] ^ pol_w;
      assign clean_w[i+1]  = clean_w[i] & ~mism_w[i];
      assign pos_next[i]   = clean_w[i] & mism_w[i];
    end
  endgenerate

  assign pos_next[W] = clean_w[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      pol_q <= 1'b0;
    end else begin
      pos_q <= pos_next;
      pol_q <= pol_w;
    end
  end

  // R2
  pos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($onehot(pos_q) && !pos_q[0]));

endmodule

// File: rtl/lead_run_binarize.sv
// Stage 2: converts the one-hot run end to binary and derives the event flag.
// The registered output polarity doubles as the previous-sample polarity.
module lead_run_binarize #(
  parameter int unsigned N = 5,
  localparam int unsigned W = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W:0]   pos_i,
  input  logic         pol_i,
  output logic [N-1:0] cnt_q,
  output logic         pol_q,
  output logic         evt_q
);

  import lead_run_pkg::*;

  logic [N-1:0] cnt_next;
  logic         flip_w;

  generate
    for (genvar b = 0; b < int'(N); b++) begin : g_bit
      localparam wide_pos_t MASK = pos_mask(b, W);
      assign cnt_next[b] = |(pos_i & MASK[W:0]);
    end
  endgenerate

  assign flip_w = pol_i ^ pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      pol_q <= pol_i;
      evt_q <= flip_w;
    end
  end

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pos_i != '0)) |-> (cnt_q != '0));

endmodule

// File: rtl/lead_run_encoder.sv
module lead_run_encoder #(
  parameter int unsigned N = 5,
  localparam int unsigned W = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec_i,
  output logic [N-1:0] cnt_o,
  output logic         pol_o,
  output logic         evt_o
);

  import lead_run_pkg::*;

  logic [W:0] s1_pos;
  logic       s1_pol;

  lead_run_locate #(.N(N)) u_locate (
    .clk   (clk),
    .rst_n (rst_n),
    .vec_i (vec_i),
    .pos_q (s1_pos),
    .pol_q (s1_pol)
  );

  lead_run_binarize #(.N(N)) u_binarize (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_i (s1_pos),
    .pol_i (s1_pol),
    .cnt_q (cnt_o),
    .pol_q (pol_o),
    .evt_q (evt_o)
  );

  // Pipeline fill tracker for the checks: pipe_full once two samples
  // taken after reset have reached the outputs.
  logic [1:0] fill_q;
  logic       pipe_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fill_q <= 2'd0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  assign pipe_full = (fill_q == 2'd2);

  // R2
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> (int'(cnt_o) == int'(lead_run(wide_vec_t'($past(vec_i, 2)), W))));

  // R1
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> (pol_o == $past(vec_i[W-1], 2)));

  // R4
  full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_full && ($past(vec_i, 2) == '0 || $past(vec_i, 2) == '1)) |-> (cnt_o == N'(W)));

  // R6
  event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o == (pol_o != $past(pol_o)));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (cnt_o == '0 && !pol_o && !evt_o));

endmodule

// File: tb/lead_run_encoder_tb.sv
module lead_run_encoder_tb;

  localparam int N = 5;
  localparam int W = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [W-1:0] vec_i = '0;
  logic [N-1:0] cnt_o;
  logic         pol_o;
  logic         evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected results for the two samples in flight: [0] newest.
  int    exp_cnt [2];
  bit    exp_pol [2];
  bit    exp_evt [2];
  bit    exp_vld [2];
  string exp_tag [2];
  bit    model_prev;

  always #4 clk = ~clk;

  lead_run_encoder #(.N(N)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .vec_i (vec_i),
    .cnt_o (cnt_o),
    .pol_o (pol_o),
    .evt_o (evt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: scan upward, the highest mismatching bit wins.
  function automatic int ref_run(input logic [W-1:0] v);
    logic [W-1:0] x;
    int r;
    x = v ^ {W{v[W-1]}};
    r = W;
    for (int i = 0; i < W; i++) if (x[i]) r = W - 1 - i;
    return r;
  endfunction

  function automatic logic [W-1:0] mk(input bit p, input int run);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) begin
      if (i < run)       v[W-1-i] = p;
      else if (i == run) v[W-1-i] = ~p;
      else               v[W-1-i] = 1'($urandom_range(1, 0));
    end
    return v;
  endfunction

  // Compare outputs against the sample from two steps back, then drive a new one.
  task automatic step(input logic [W-1:0] v, input string tg);
    if (exp_vld[1]) begin
      check(int'(cnt_o) == exp_cnt[1], {"R2 count ", exp_tag[1]}, int'(cnt_o), exp_cnt[1]);
      check(pol_o == exp_pol[1], {"R1 polarity ", exp_tag[1]}, int'(pol_o), int'(exp_pol[1]));
      check(evt_o == exp_evt[1], {"R6 event ", exp_tag[1]}, int'(evt_o), int'(exp_evt[1]));
    end
    exp_cnt[1] = exp_cnt[0]; exp_pol[1] = exp_pol[0];
    exp_evt[1] = exp_evt[0]; exp_vld[1] = exp_vld[0]; exp_tag[1] = exp_tag[0];
    exp_cnt[0] = ref_run(v);
    exp_pol[0] = v[W-1];
    exp_evt[0] = v[W-1] != model_prev;
    exp_vld[0] = 1'b1;
    exp_tag[0] = tg;
    model_prev = v[W-1];
    vec_i = v;
    @(negedge clk);
  endtask

  task automatic drain();
    step(mk(model_prev, 3), "drain");
    step(mk(model_prev, 3), "drain");
  endtask

  task automatic do_reset();
    vec_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero during reset
    check(cnt_o == '0, "R8 count in reset", int'(cnt_o), 0);
    check(pol_o == 1'b0, "R8 polarity in reset", int'(pol_o), 0);
    check(evt_o == 1'b0, "R8 event in reset", int'(evt_o), 0);
    rst_n = 1'b1;
    exp_vld[0] = 1'b0;
    exp_vld[1] = 1'b0;
    model_prev = 1'b0;
  endtask

  // R5 R7: ramp of run lengths with polarity alternating every clock.
  task automatic t_ramp();
    for (int i = 1; i < W; i++) step(mk(i[0], i), "R7 R5 ramp");
    step({W{1'b0}}, "R4 R7 ramp end");
    drain();
  endtask

  // R3: same leading run and mismatch, random lower bits, same polarity.
  task automatic t_tail();
    for (int k = 0; k < 8; k++) step(mk(1'b1, 7), "R3 tail p1");
    step({1'b1, 1'b1, 1'b0, {(W-3){1'b0}}}, "R3 tail zeros");
    step({1'b1, 1'b1, 1'b0, {(W-3){1'b1}}}, "R3 tail ones");
    for (int k = 0; k < 6; k++) step(mk(1'b0, 20), "R3 tail p0");
    step(mk(1'b0, W - 1), "R2 last-bit mismatch");
    step(mk(1'b1, 1), "R2 top-only run");
    drain();
  endtask

  // R4: all-equal samples of both polarities, repeated and alternating.
  task automatic t_full();
    step({W{1'b1}}, "R4 ones");
    step({W{1'b1}}, "R4 ones again");
    step({W{1'b0}}, "R4 zeros");
    step({W{1'b1}}, "R4 ones after zeros");
    drain();
  endtask

  // R8: reset mid-stream, then first sample of each polarity.
  task automatic t_reset_first();
    step(mk(1'b1, 9), "R8 before reset");
    do_reset();
    step(mk(1'b0, 5), "R8 first p0");
    step(mk(1'b0, 6), "R8 second p0");
    drain();
    do_reset();
    step(mk(1'b1, 4), "R8 first p1");
    step(mk(1'b1, 4), "R8 second p1");
    drain();
  endtask

  initial begin
    exp_vld[0] = 1'b0;
    exp_vld[1] = 1'b0;
    model_prev = 1'b0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    t_ramp();
    t_tail();
    t_full();
    t_reset_first();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule